// File: doc/BRIEF.md
# Blinking GPIO Bank with Change-of-State Fault

This block manages a small bank of general-purpose pins. Each pin can be an input, or an open-drain output that only pulls low. An output pin can hold a steady level or blink an LED at a fixed rate set by a shared free-running divider. Every pin's level is resynchronised into the clock domain. When its fault enable is set, any change of that level raises a sticky fault flag. The flag holds until software writes a one to clear it, or until reset.

Software reaches the bank through a plain synchronous port. A write takes one clock cycle and a read is combinational. The port gives access to the per-pin direction, output level, blink enable and fault enable fields, to a fault status field that is cleared by writing ones, and to a read-only view of the synchronised pin levels. When any fault flag is set, the bank asserts one drive-low enable for a shared active-low open-drain fault line.

Top module: `gpio_blink_fault`

## Requirements
- R1: The bank has NUM_PINS pins (default 4). In the register at address 0, bit i set to 1 makes pin i an output and 0 makes it an input. `pin_drive_low[i]`=1 means the pin is pulled low, and 0 means it is released.
- R2: A pin in input mode is never pulled low, whatever its output, blink or fault bits hold.
- R3: An output pin whose blink bit is clear follows its bit in the output-level register (address 1): level 0 pulls the pin low and level 1 releases it.
- R4: An output pin whose blink bit (address 2) is set ignores its output-level bit. It is pulled low exactly when the shared blink phase is 1. The phase is 0 for the first 2^BLINK_LOG2 clock edges after reset release and then toggles every 2^BLINK_LOG2 edges, so all blinking pins stay in step.
- R5: Reset is synchronous and active high. It clears every register, so all pins are inputs with fault generation off, no fault is flagged, and the fault line is released.
- R6: When a pin's fault-enable bit (address 3) is set, a change of its level raises bit i of the fault status (address 4). The flag becomes visible after the third rising edge that samples the new level, because the path is two synchronizer stages plus one edge-compare stage.
- R7: A fault flag is sticky. It stays set while the pin holds still or changes again, and a pin whose fault-enable bit is clear never raises one.
- R8: Writing to address 4 clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. If a clear and a new change land on the same edge, the flag ends up set.
- R9: `fault_drive_low` is 1 exactly when at least one fault flag is set.
- R10: Addresses 0 to 3 read back what was written to them. Address 4 reads the fault flags, address 5 reads the synchronised levels, and every other address reads 0. Writes to address 5 and to unused addresses change nothing.
- R11: Address 5 shows each pin's level as sampled two rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | NUM_PINS | Write data, one bit per pin |
| rd_addr | input | ADDR_W | Read register address |
| rd_data | output | NUM_PINS | Combinational read data |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_drive_low | output | NUM_PINS | Per-pin pull-down enable |
| fault_drive_low | output | 1 | Pull-down enable for the shared active-low fault line |

## Verification
The assertions assume that reset is held for at least one rising edge before any check starts. They also assume the write strobe, address and data are stable around each rising edge. The bench meets both conditions by driving every input on the falling edge and asserting reset for several cycles. The pin inputs are treated as fully asynchronous to the logic but are in fact driven on falling edges, which gives the synchronizer clean samples. A reference model can then predict on which edge each fault becomes visible. The random phase toggles pins and issues writes at moderate rates, so that clears sometimes land on the same edge as new change events.

// File: rtl/gbf_pkg.sv
package gbf_pkg;
   // Register addresses; software decodes these, so they are fixed.
   localparam int unsigned A_DIR    = 0;
   localparam int unsigned A_LEVEL  = 1;
   localparam int unsigned A_BLINK  = 2;
   localparam int unsigned A_FEN    = 3;
   localparam int unsigned A_FSTAT  = 4;
   localparam int unsigned A_SYNC   = 5;
   localparam int unsigned NUM_REGS = 6;
endpackage

// File: rtl/gbf_sync.sv
module gbf_sync #(
   parameter int unsigned NUM_PINS    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] level,
   output logic [NUM_PINS-1:0] change
);
   localparam int unsigned LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0][NUM_PINS-1:0] chain_q;
   logic [NUM_PINS-1:0]                  prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
         prev_q  <= '0;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], pin_in};
         prev_q  <= chain_q[LAST];
      end
   end

   assign level  = chain_q[LAST];
   assign change = chain_q[LAST] ^ prev_q;

   // A flagged change must be followed by a steady level unless the input moved again
   AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      ((change != '0) && (chain_q[LAST] == chain_q[LAST-1])) |=> ((change & $past(change)) == '0)); // R7
endmodule

// File: rtl/gbf_blink.sv
module gbf_blink #(
   parameter int unsigned BLINK_LOG2 = 16
) (
   input  logic clk,
   input  logic rst,
   output logic phase
);
   logic [BLINK_LOG2-1:0] div_q;
   logic                  phase_q;
   logic                  wrap;

   assign wrap = &div_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q   <= '0;
         phase_q <= 1'b0;
      end else begin
         div_q <= div_q + 1'b1;
         if (wrap) phase_q <= ~phase_q;
      end
   end

   assign phase = phase_q;

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> $stable(phase_q)); // R4
endmodule

// File: rtl/gbf_regs.sv
module gbf_regs
   import gbf_pkg::*;
#(
   parameter int unsigned NUM_PINS = 4,
   parameter int unsigned ADDR_W   = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [NUM_PINS-1:0] wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [NUM_PINS-1:0] rd_data,
   input  logic [NUM_PINS-1:0] set_vec,
   input  logic [NUM_PINS-1:0] sync_level,
   output logic [NUM_PINS-1:0] dir,
   output logic [NUM_PINS-1:0] lvl,
   output logic [NUM_PINS-1:0] blk,
   output logic [NUM_PINS-1:0] fen,
   output logic [NUM_PINS-1:0] fault
);
   logic [NUM_PINS-1:0] dir_q, lvl_q, blk_q, fen_q;
   logic [NUM_PINS-1:0] clr_vec;

   assign clr_vec = (wr_en && wr_addr == ADDR_W'(A_FSTAT)) ? wr_data : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         dir_q <= '0;
         lvl_q <= '0;
         blk_q <= '0;
         fen_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(A_DIR))   dir_q <= wr_data;
         if (wr_addr == ADDR_W'(A_LEVEL)) lvl_q <= wr_data;
         if (wr_addr == ADDR_W'(A_BLINK)) blk_q <= wr_data;
         if (wr_addr == ADDR_W'(A_FEN))   fen_q <= wr_data;
      end
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk) begin
         if (rst)               flag_q <= 1'b0;
         else if (set_vec[i])   flag_q <= 1'b1;
         else if (clr_vec[i])   flag_q <= 1'b0;
      end
      assign fault[i] = flag_q;

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
         (flag_q && !clr_vec[i]) |=> flag_q); // R7
      AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
         set_vec[i] |=> flag_q); // R8
      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
         (clr_vec[i] && !set_vec[i]) |=> !flag_q); // R8
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(A_DIR):   rd_data = dir_q;
         ADDR_W'(A_LEVEL): rd_data = lvl_q;
         ADDR_W'(A_BLINK): rd_data = blk_q;
         ADDR_W'(A_FEN):   rd_data = fen_q;
         ADDR_W'(A_FSTAT): rd_data = fault;
         ADDR_W'(A_SYNC):  rd_data = sync_level;
         default:          rd_data = '0;
      endcase
   end

   assign dir = dir_q;
   assign lvl = lvl_q;
   assign blk = blk_q;
   assign fen = fen_q;

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (dir_q == '0 && fen_q == '0 && blk_q == '0 && fault == '0)); // R5
endmodule

// File: rtl/gpio_blink_fault.sv
module gpio_blink_fault
   import gbf_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 4,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BLINK_LOG2  = 16,
   parameter bit          HAS_BLINK   = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [NUM_PINS-1:0] wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [NUM_PINS-1:0] rd_data,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_drive_low,
   output logic                fault_drive_low
);
   localparam int unsigned ADDR_SPACE = 1 << ADDR_W;

   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_SPACE < NUM_REGS) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (BLINK_LOG2 < 1 || BLINK_LOG2 > 30) begin : g_bad_blink
      $error("BLINK_LOG2 must lie in 1..30");
   end

   logic [NUM_PINS-1:0] level, change, fault_set;
   logic [NUM_PINS-1:0] dir, lvl, blk, fen, fault;
   logic                phase;

   gbf_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .pin_in(pin_in), .level(level), .change(change)
   );

   assign fault_set = fen & change;

   gbf_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .set_vec(fault_set), .sync_level(level),
      .dir(dir), .lvl(lvl), .blk(blk), .fen(fen), .fault(fault)
   );

   if (HAS_BLINK) begin : g_blink
      gbf_blink #(.BLINK_LOG2(BLINK_LOG2)) u_blink (
         .clk(clk), .rst(rst), .phase(phase)
      );
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_drv
         assign pin_drive_low[i] = dir[i] & (blk[i] ? phase : ~lvl[i]);
      end
   end else begin : g_steady
      assign phase = 1'b0;
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_drv
         assign pin_drive_low[i] = dir[i] & ~lvl[i] & ~(blk[i] & phase);
      end
   end

   assign fault_drive_low = |fault;

   AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (rst)
      (pin_drive_low & ~dir) == '0); // R2
   AST_FAULT_LINE: assert property (@(posedge clk) disable iff (rst)
      (fault_set != '0) |=> fault_drive_low); // R9
endmodule

// File: tb/tb_gpio_blink_fault.sv
`timescale 1ns/100ps
module tb_gpio_blink_fault;
   localparam int NP = 4;
   localparam int AW = 3;
   localparam int LG = 3;

   logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [NP-1:0] wr_data = '0, pin_in = '0;
   logic [NP-1:0] rd_data, pin_drive_low;
   logic          fault_drive_low;

   gpio_blink_fault #(.NUM_PINS(NP), .ADDR_W(AW), .BLINK_LOG2(LG)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in),
      .pin_drive_low(pin_drive_low), .fault_drive_low(fault_drive_low)
   );

   always #2 clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // behavioural reference model
   logic [NP-1:0] m_dir, m_lvl, m_blk, m_fen, m_flt;
   logic [NP-1:0] hist[$];
   int            edges;

   function automatic logic [NP-1:0] exp_drive();
      logic [NP-1:0] d;
      logic ph;
      ph = ((edges >> LG) & 1) != 0;
      for (int i = 0; i < NP; i++)
         d[i] = m_dir[i] ? (m_blk[i] ? ph : ~m_lvl[i]) : 1'b0;
      return d;
   endfunction

   function automatic logic [NP-1:0] exp_read(int a);
      case (a)
         0: return m_dir;
         1: return m_lvl;
         2: return m_blk;
         3: return m_fen;
         4: return m_flt;
         5: return hist[1];
         default: return '0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_dir = '0; m_lvl = '0; m_blk = '0; m_fen = '0; m_flt = '0;
         hist = {4'h0, 4'h0, 4'h0, 4'h0};
         edges = 0;
      end else begin
         logic [NP-1:0] setv, clrv;
         setv = m_fen & (hist[1] ^ hist[2]);
         clrv = (wr_en && wr_addr == 3'd4) ? wr_data : '0;
         if (wr_en) begin
            case (wr_addr)
               3'd0: m_dir = wr_data;
               3'd1: m_lvl = wr_data;
               3'd2: m_blk = wr_data;
               3'd3: m_fen = wr_data;
               default: ;
            endcase
         end
         m_flt = (m_flt & ~clrv) | setv;
         hist.push_front(pin_in);
         void'(hist.pop_back());
         edges++;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      #0.5;
      if (!rst && !done) begin
         chk("R1 R2 R3 R4 pin drive", pin_drive_low, exp_drive());
         chk("R9 fault line", fault_drive_low, m_flt != '0);
         chk("R10 R11 read data", rd_data, exp_read(int'(rd_addr)));
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int a, logic [NP-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(int a, output logic [NP-1:0] v);
      rd_addr = AW'(a);
      #0.2;
      v = rd_data;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL R5 watchdog actual=hung expected=finished");
         done = 1'b1;
         finish_run();
      end
   end

   initial begin
      logic [NP-1:0] v;
      int lows;
      cyc(4);
      rst = 1'b0;
      // R5: reset state
      cyc(1);
      for (int a = 0; a < 5; a++) begin
         rd(a, v); chk("R5 reset register", v, 0);
      end
      chk("R5 pins released", pin_drive_low, 0);
      chk("R5 fault line released", fault_drive_low, 0);

      // R1 R3: steady outputs
      wr(1, 4'h5);
      wr(0, 4'hF);
      cyc(1);
      chk("R3 steady output drive", pin_drive_low, 4'hA);
      rd(0, v); chk("R10 direction readback", v, 4'hF);
      // R2: inputs not driven
      wr(1, 4'h0);
      wr(0, 4'h3);
      cyc(1);
      chk("R2 input pins released", pin_drive_low, 4'h3);

      // R4: blinking pin 0 with output level 1 spends half of a full period low
      wr(1, 4'h1);
      wr(2, 4'h1);
      lows = 0;
      for (int k = 0; k < (2 << LG); k++) begin
         cyc(1);
         if (pin_drive_low[0]) lows++;
      end
      chk("R4 blink duty", lows, 1 << LG);
      wr(2, 4'h0);
      wr(0, 4'h0);

      // R6: change fault timing on pin 2
      wr(3, 4'h7);
      cyc(4);
      pin_in[2] = 1'b1;
      cyc(2);
      rd(4, v); chk("R6 no flag before third edge", v, 0);
      cyc(1);
      rd(4, v); chk("R6 flag after third edge", v, 4'h4);
      chk("R9 fault line asserted", fault_drive_low, 1);
      rd(5, v); chk("R11 synchronised level", v, 4'h4);
      // R7: sticky while stable
      cyc(10);
      rd(4, v); chk("R7 flag held", v, 4'h4);
      // R8: zero bits do not clear, one bits do
      wr(4, 4'hB);
      rd(4, v); chk("R8 zero bit keeps flag", v, 4'h4);
      wr(4, 4'h4);
      rd(4, v); chk("R8 one bit clears flag", v, 4'h0);
      chk("R9 fault line released", fault_drive_low, 0);

      // R8: set wins over a simultaneous clear on pin 1
      pin_in[1] = 1'b1;
      cyc(2);
      wr_en = 1'b1; wr_addr = 3'd4; wr_data = 4'h2;
      cyc(1);
      wr_en = 1'b0;
      rd(4, v); chk("R8 set wins over clear", v, 4'h2);
      wr(4, 4'hF);

      // R7: disabled pin 3 never flags
      pin_in[3] = 1'b1; cyc(5); pin_in[3] = 1'b0; cyc(5);
      rd(4, v); chk("R7 disabled pin no flag", v, 4'h0);

      // R10: read-only and unused addresses
      wr(5, 4'hF);
      wr(7, 4'hF);
      rd(6, v); chk("R10 unused reads zero", v, 0);
      rd(0, v); chk("R10 writes elsewhere ignored", v, 4'h0);
      rd(5, v); chk("R11 level unaffected by write", v, 4'h6);

      // random phase, compared every cycle against the model
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if ($urandom_range(7) == 0) pin_in[$urandom_range(NP-1)] ^= 1'b1;
         wr_en   = ($urandom_range(5) == 0);
         wr_addr = AW'($urandom);
         wr_data = NP'($urandom);
         rd_addr = AW'($urandom);
      end
      @(negedge clk);
      wr_en = 1'b0;
      cyc(2);
      done = 1'b1;
      finish_run();
   end
endmodule